// File: doc/BRIEF.md
# Dual Latch-Reload Interval Timer

This block holds two 16-bit down-counters behind a byte-wide register window. A bus master picks a register with a four-bit index taken from address bits 12:9, and reads or writes one byte per access. The first counter reloads from a 16-bit latch each time it passes below zero, so it makes a steady periodic event. The second counter is loaded once from a byte pair and then runs down and wraps without reloading, so it acts as a one-shot interval.

Both counters step once for each pulse of an internal tick. A prescaler divides the system clock to make that tick. The block does not hold interrupt flags. It sends single-cycle set requests when a counter reaches zero, and clear requests when a register access has that side effect. A separate flag register consumes both kinds of request. A two-bit mode input selects whether the first counter's zero crossing sends a set request.

Top module: `dual_interval_timer`

## Requirements
- R1: The register index is `bus_addr[12:9]`. Reads return: index 4 = counter A low byte, 5 = counter A high byte, 6 = latch A low byte, 7 = latch A high byte, 8 = counter B low byte, 9 = counter B high byte. Any other index reads 0x00. Address bits 8:0 have no effect.
- R2: After reset, latch A, counter A and counter B are all 0xFFFF.
- R3: A write to index 4 or index 6 replaces only the low byte of latch A. Counter A is unchanged and no clear request is sent.
- R4: A write to index 5 does three things: it replaces the high byte of latch A, it loads counter A with the new full latch value, and it sends a counter-A clear request in the cycle of the access.
- R5: A write to index 7 replaces the high byte of latch A and sends a counter-A clear request. Counter A is not reloaded.
- R6: On each tick, counter A decrements. When it is at 0xFFFF, the tick reloads it from latch A instead. The period is therefore latch+2 ticks.
- R7: When `t1_mode` is 2'b01, each tick that brings counter A to 0x0000 produces a one-cycle `t1_set` pulse in the following cycle.
- R8: When `t1_mode` is any other value, `t1_set` stays low.
- R9: A read of index 4 drives `t1_clr` high in that access cycle. A read of index 8 drives `t2_clr` high. A read of any other index drives neither.
- R10: A write to index 8 stores the data byte as the low byte of latch B and loads counter B with {0x00, data}. A write to index 9 loads counter B with {data, stored low byte}.
- R11: Counter B decrements on each tick and wraps from 0x0000 to 0xFFFF without reloading. The first time it reaches 0x0000 after a load, `t2_set` pulses for one cycle. Later crossings do not pulse until counter B is loaded again.
- R12: `tick` is high for one cycle out of every `TICK_DIV` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 13 | Byte address; bits 12:9 give the register index |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle (drives the clear side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the indexed register (combinational) |
| t1_mode | input | 2 | Counter A mode; 2'b01 selects continuous interrupts |
| tick | output | 1 | Prescaled count enable |
| t1_set | output | 1 | Counter A set request pulse |
| t1_clr | output | 1 | Counter A clear request |
| t2_set | output | 1 | Counter B set request pulse |
| t2_clr | output | 1 | Counter B clear request |

## Verification
The bench targets the point where counter A passes through 0xFFFF. A design that reloaded at zero would run one tick short of a latch+2 period. A design that skipped 0xFFFF would never show that value in readback. The bench separates the high-byte write that loads counter A from the one that does not, so a design that reloaded on both would show the wrong count. It also runs a zero latch, where the crossing comes from the reload itself. Counter B is run past its first wrap. A design that reloaded it, or that sent a set request on every crossing, would show an extra pulse or the wrong count.

// File: rtl/timer_pkg.sv
// Package: shared register indices for the dual interval timer.
// Assumes a four-bit index window; unlisted indices are unmapped.
package timer_pkg;
    typedef enum logic [3:0] {
        IDX_A_CNT_LO = 4'd4,
        IDX_A_CNT_HI = 4'd5,
        IDX_A_LAT_LO = 4'd6,
        IDX_A_LAT_HI = 4'd7,
        IDX_B_CNT_LO = 4'd8,
        IDX_B_CNT_HI = 4'd9
    } reg_idx_e;
endpackage

// File: rtl/tick_prescaler.sv
// Module: divides the system clock into a one-cycle count enable.
// Assumes DIV >= 2; the tick is high when the divider sits at DIV-1.
module tick_prescaler #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] div_q;

    // Purpose: step the divider and wrap after its last value.
    always_ff @(posedge clk) begin
        if (!rst_n)             div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == LAST);

    generate
        if (DIV > 1) begin : g_spacing
            // R12: a tick is never followed directly by another
            assert_tick_spacing_R12: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/reload_counter.sv
// Module: counter A. A 16-bit down-counter with a 16-bit reload latch.
// Counts latch..0, then 0xFFFF, then reloads: period latch+2 ticks.
// Assumes a bus write and a tick may coincide; the load wins.
module reload_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_lat_lo,
    input  logic         wr_lat_hi_load,
    input  logic         wr_lat_hi_only,
    input  logic [7:0]   wdata,
    input  logic         cont_mode,
    output logic [W-1:0] count,
    output logic [W-1:0] latch,
    output logic         set_pulse
);
    localparam logic [W-1:0] ALL1 = '1;

    logic [W-1:0] nxt;

    // Purpose: choose the next counter value from load, reload or decrement.
    always_comb begin
        nxt = count;
        if (wr_lat_hi_load)    nxt = {wdata, latch[7:0]};
        else if (tick)         nxt = (count == ALL1) ? latch : count - 1'b1;
    end

    // Purpose: hold the latch bytes and the running count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch <= ALL1;
            count <= ALL1;
        end else begin
            if (wr_lat_lo)                        latch[7:0]   <= wdata;
            if (wr_lat_hi_load || wr_lat_hi_only) latch[W-1:8] <= wdata;
            count <= nxt;
        end
    end

    // Purpose: flag a tick that lands the count on zero in continuous mode.
    always_ff @(posedge clk) begin
        if (!rst_n) set_pulse <= 1'b0;
        else        set_pulse <= cont_mode && tick && !wr_lat_hi_load && (nxt == '0);
    end

    // R4: the loading high write places the full latch in the counter
    assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lat_hi_load |=> count == {$past(wdata), $past(latch[7:0])});
    // R5: the plain high write leaves the count alone
    assert_no_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lat_hi_only && !tick) |=> $stable(count));
    // R6: passing 0xFFFF brings back the latch
    assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_lat_hi_load && count == ALL1) |=> count == $past(latch));
    // R8: no set request outside continuous mode
    assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cont_mode |=> !set_pulse);
endmodule

// File: rtl/oneshot_counter.sv
// Module: counter B. A 16-bit down-counter loaded from a byte pair.
// Wraps freely; signals its first zero after each load.
// Assumes a load and a tick may coincide; the load wins.
module oneshot_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic [7:0]   wdata,
    output logic [W-1:0] count,
    output logic         set_pulse
);
    logic [7:0]   lo_q;
    logic         armed;
    logic [W-1:0] nxt;
    logic         fire;

    // Purpose: choose the next counter value from the two loads or a decrement.
    always_comb begin
        nxt = count;
        if (wr_lo)      nxt = {{(W-8){1'b0}}, wdata};
        else if (wr_hi) nxt = {wdata, lo_q};
        else if (tick)  nxt = count - 1'b1;
    end

    assign fire = armed && tick && !wr_lo && !wr_hi && (nxt == '0);

    // Purpose: hold the stored low byte, the count and the one-shot arm bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q      <= '0;
            count     <= '1;
            armed     <= 1'b0;
            set_pulse <= 1'b0;
        end else begin
            if (wr_lo) lo_q <= wdata;
            count     <= nxt;
            set_pulse <= fire;
            if (wr_lo || wr_hi) armed <= 1'b1;
            else if (fire)      armed <= 1'b0;
        end
    end

    // R10: the high write joins the data with the stored low byte
    assert_hi_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi && !wr_lo |=> count == {$past(wdata), $past(lo_q)});
    // R11: zero wraps to all ones with no reload
    assert_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_lo && !wr_hi && count == '0) |=> count == '1);
    // R11: one pulse per load
    assert_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |-> !armed || $past(wr_lo || wr_hi));
endmodule

// File: rtl/dual_interval_timer.sv
// Module: top of the dual interval timer. Decodes the byte register window,
// steers writes to the two counters, muxes read data and drives the
// flag set and clear requests. Assumes one access per cycle.
module dual_interval_timer #(
    parameter int ADDR_W   = 13,
    parameter int TICK_DIV = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [1:0]        t1_mode,
    output logic              tick,
    output logic              t1_set,
    output logic              t1_clr,
    output logic              t2_set,
    output logic              t2_clr
);
    import timer_pkg::*;

    localparam int CNT_W   = 16;
    localparam int IDX_LSB = ADDR_W - 4;

    logic [3:0]       idx;
    logic             addr_unused;
    logic [CNT_W-1:0] a_count, a_latch, b_count;
    logic             w_a_lo, w_a_hi_ld, w_a_hi, w_b_lo, w_b_hi;

    assign idx         = bus_addr[ADDR_W-1:IDX_LSB];
    assign addr_unused = ^bus_addr[IDX_LSB-1:0];

    assign w_a_lo    = bus_wr && (idx == IDX_A_CNT_LO || idx == IDX_A_LAT_LO);
    assign w_a_hi_ld = bus_wr && (idx == IDX_A_CNT_HI);
    assign w_a_hi    = bus_wr && (idx == IDX_A_LAT_HI);
    assign w_b_lo    = bus_wr && (idx == IDX_B_CNT_LO);
    assign w_b_hi    = bus_wr && (idx == IDX_B_CNT_HI);

    assign t1_clr = w_a_hi_ld || w_a_hi || (bus_rd && idx == IDX_A_CNT_LO);
    assign t2_clr = bus_rd && (idx == IDX_B_CNT_LO);

    tick_prescaler #(.DIV(TICK_DIV)) u_presc (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    reload_counter #(.W(CNT_W)) u_cnt_a (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .wr_lat_lo(w_a_lo), .wr_lat_hi_load(w_a_hi_ld), .wr_lat_hi_only(w_a_hi),
        .wdata(bus_wdata), .cont_mode(t1_mode == 2'b01),
        .count(a_count), .latch(a_latch), .set_pulse(t1_set)
    );

    oneshot_counter #(.W(CNT_W)) u_cnt_b (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .wr_lo(w_b_lo), .wr_hi(w_b_hi), .wdata(bus_wdata),
        .count(b_count), .set_pulse(t2_set)
    );

    // Purpose: return the byte of the indexed register, zero when unmapped.
    always_comb begin
        case (idx)
            IDX_A_CNT_LO: bus_rdata = a_count[7:0];
            IDX_A_CNT_HI: bus_rdata = a_count[15:8];
            IDX_A_LAT_LO: bus_rdata = a_latch[7:0];
            IDX_A_LAT_HI: bus_rdata = a_latch[15:8];
            IDX_B_CNT_LO: bus_rdata = b_count[7:0];
            IDX_B_CNT_HI: bus_rdata = b_count[15:8];
            default:      bus_rdata = 8'h00;
        endcase
    end

    // R3: a low-byte latch write never disturbs the count
    assert_lat_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (w_a_lo && !tick) |=> $stable(a_count));
    // R9: the two clear requests come from different accesses
    assert_clr_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(t1_clr && t2_clr));
endmodule

// File: tb/dual_interval_timer_bench.sv
module dual_interval_timer_bench;
    localparam int CLK_P = 10;
    localparam int DIV   = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [1:0]  t1_mode = 2'b01;
    logic        tick, t1_set, t1_clr, t2_set, t2_clr;

    int checks = 0, errors = 0;
    int n1 = 0, n2 = 0;
    logic c1, c2;

    always #(CLK_P/2) clk = ~clk;

    dual_interval_timer #(.ADDR_W(13), .TICK_DIV(DIV)) u_dual_interval_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .t1_mode(t1_mode), .tick(tick), .t1_set(t1_set), .t1_clr(t1_clr),
        .t2_set(t2_set), .t2_clr(t2_clr)
    );

    // count set pulses away from the active edge
    always @(negedge clk) if (rst_n) begin
        if (t1_set) n1++;
        if (t2_set) n2++;
    end

    // {latch, ticks after load}
    localparam logic [31:0] VEC [8] = '{
        {16'd3, 16'd2}, {16'd3, 16'd4}, {16'd3, 16'd5}, {16'd3, 16'd12},
        {16'd0, 16'd3}, {16'd1, 16'd7}, {16'd5, 16'd6}, {16'h0102, 16'd9}};

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sync();
        @(negedge clk);
        while (!tick) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic wr(input logic [3:0] idx, input logic [7:0] d);
        @(negedge clk);
        bus_addr = {idx, 9'h0A5}; bus_wdata = d; bus_wr = 1'b1;
        #1; c1 = t1_clr; c2 = t2_clr;
        @(posedge clk);
        #1; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [7:0] d);
        @(negedge clk);
        bus_addr = {idx, 9'h1FF}; bus_rd = 1'b1;
        #1; d = bus_rdata; c1 = t1_clr; c2 = t2_clr;
        @(posedge clk);
        #1; bus_rd = 1'b0;
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) sync();
    endtask

    task automatic rd16(input logic [3:0] lo_idx, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(lo_idx, lo);
        rd(lo_idx + 4'd1, hi);
        v = {hi, lo};
    endtask

    function automatic logic [15:0] a_val(input int L, input int n);
        return 16'(L - (n % (L + 2)));
    endfunction

    initial begin
        logic [7:0]  b;
        logic [15:0] v;
        int          base, cyc, expn;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R2 reset values, R1 decode
        rd16(4'd4, v); chk("R2 counter A", v, 16'hFFFF);
        rd16(4'd6, v); chk("R2 latch A", v, 16'hFFFF);
        rd16(4'd8, v); chk("R2 counter B", v, 16'hFFFF);
        rd(4'd2, b);   chk("R1 unmapped index", b, 0);
        rd(4'd15, b);  chk("R1 unmapped index 15", b, 0);

        // R12 tick spacing
        sync(); cyc = 0;
        @(negedge clk); cyc = 1;
        while (!tick) begin @(negedge clk); cyc++; end
        chk("R12 tick interval", cyc, DIV);

        // R6/R7 vector walk in continuous mode
        t1_mode = 2'b01;
        foreach (VEC[i]) begin
            int L, n;
            L = int'(VEC[i][31:16]); n = int'(VEC[i][15:0]);
            sync();
            wr(4'd4, VEC[i][23:16]);
            wr(4'd5, VEC[i][31:24]);
            base = n1;
            step(n);
            rd16(4'd4, v);
            chk("R6 counter A after ticks", v, a_val(L, n));
            expn = 0;
            for (int k = 1; k <= n; k++) if (a_val(L, k) == 16'h0) expn++;
            chk("R7 set pulses", n1 - base, expn);
        end

        // R3 / R4 / R5 latch byte writes
        sync();
        wr(4'd4, 8'h03); chk("R3 no clear on latch-low write", c1, 0);
        wr(4'd5, 8'h00); chk("R4 clear on loading write", c1, 1);
        wr(4'd6, 8'h09);
        rd16(4'd6, v); chk("R3 latch low replaced", v, 16'h0009);
        rd16(4'd4, v); chk("R3 counter untouched", v, 16'h0003);
        wr(4'd7, 8'h01); chk("R5 clear on plain high write", c1, 1);
        rd16(4'd6, v); chk("R5 latch high replaced", v, 16'h0109);
        rd16(4'd4, v); chk("R5 counter not reloaded", v, 16'h0003);
        step(4);
        rd16(4'd4, v); chk("R6 passes through FFFF", v, 16'hFFFF);
        step(1);
        rd16(4'd4, v); chk("R6 reload from new latch", v, 16'h0109);

        // R8 other modes
        for (int m = 0; m < 4; m++) begin
            if (m == 1) continue;
            t1_mode = 2'(m);
            sync(); wr(4'd4, 8'h02); wr(4'd5, 8'h00);
            base = n1;
            step(9);
            chk("R8 no set pulse outside continuous", n1 - base, 0);
        end
        t1_mode = 2'b01;

        // R9 read side effects
        sync();
        rd(4'd4, b); chk("R9 read A low clears A", c1, 1);
        chk("R9 read A low leaves B", c2, 0);
        rd(4'd8, b); chk("R9 read B low clears B", c2, 1);
        chk("R9 read B low leaves A", c1, 0);
        rd(4'd6, b); chk("R9 other read no clear", {c1, c2}, 0);

        // R10 / R11 counter B
        sync();
        wr(4'd8, 8'h03);
        rd16(4'd8, v); chk("R10 low write loads counter B", v, 16'h0003);
        base = n2;
        step(3);
        rd16(4'd8, v); chk("R11 counter B at zero", v, 16'h0000);
        chk("R11 one set pulse", n2 - base, 1);
        step(1);
        rd16(4'd8, v); chk("R11 wraps without reload", v, 16'hFFFF);
        step(3);
        rd16(4'd8, v); chk("R11 keeps counting", v, 16'hFFFC);
        chk("R11 still one pulse", n2 - base, 1);
        wr(4'd9, 8'h12);
        rd16(4'd8, v); chk("R10 high write joins stored low", v, 16'h1203);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule